// File: doc/BRIEF.md
# Auto-increment word programming sequencer

This block runs the auto-address-increment programming session of a serial flash slave. An SPI front end ahead of it shifts in each chip-select frame. It hands this block the frame's opcode on a one-cycle strobe, each later byte on a second strobe, and a pulse when chip select goes high. The block keeps the session state between frames. It writes the data bytes into a memory array model one byte per cycle, and it raises a busy flag for the length of each self-timed program pulse.

The opening frame of a session carries a 24-bit start address and two data bytes. Each frame after that carries only two data bytes, which go to the next even/odd address pair. While a session is running, only another auto-increment frame or a write-disable opcode has any effect. The serial output can optionally be driven as a ready/busy line for the whole session. The array model ANDs each written byte into the stored one, so only erased (FFh) locations take a new value cleanly. Keeping to erased locations is the job of the software.

Top module: `aai_word_prog`

## Requirements
- R1: The write-enable opcode 06h sets the `wel` latch when no session is running. An auto-increment opcode ADh starts a session only when `wel` is 1 and `busy` is 0. Otherwise the whole frame is ignored.
- R2: The first frame is ADh, then three address bytes sent most significant first, then two data bytes. Bit 0 of the start address is forced to 0. The first data byte goes to that even address and the second to the address one above it. `aai_active` rises in the cycle after the frame's last data byte has been taken.
- R3: Each later ADh frame in a session programs its two data bytes at the current pair address and that address + 1. The pair address then advances by 2.
- R4: Once a pair is accepted, `mem_we` is high for two consecutive cycles. The first cycle writes the even byte and the second writes the odd byte.
- R5: `busy` is high for exactly PROG_CYCLES cycles, starting in the cycle of the first write of a pair.
- R6: An ADh frame whose opcode arrives while `busy` is 1 is ignored, and its data is discarded.
- R7: While a session is running, every opcode other than ADh and 04h is ignored. This includes 06h, 70h and 80h.
- R8: The write-disable opcode 04h ends any session and clears `wel`.
- R9: When `prot_on` is 1 and either byte of a pair has an address >= `prot_floor`, the pair produces no write and no busy time. The pair address still advances by 2.
- R10: Programming the pair at the top of the array ends the session and clears `wel`. The address never wraps around.
- R11: Opcode 70h, given outside a session, turns the ready/busy output on, and 80h turns it off. `so_oe` is 1 only while this output is on and a session is running. `so_q` is the inverse of `busy`.
- R12: A frame that ends before its second data byte programs nothing. Bytes after the second data byte are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Opcode strobe, first byte of a frame |
| cmd_op | input | 8 | Opcode value |
| dat_valid | input | 1 | Strobe for each later byte in the frame |
| dat_byte | input | 8 | Byte value |
| frame_end | input | 1 | Pulse when chip select is released |
| prot_on | input | 1 | Block protection enabled |
| prot_floor | input | AW | Lowest protected byte address |
| mem_we | output | 1 | Byte write request to the array |
| mem_addr | output | AW | Write address |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Program pulse in progress |
| aai_active | output | 1 | Session running |
| wel | output | 1 | Write-enable latch |
| so_oe | output | 1 | Serial output driven as ready/busy |
| so_q | output | 1 | Ready/busy level (1 = ready) |

## Verification
The bench builds the block with AW = 6, a 64-byte array, and PROG_CYCLES = 4. The small array lets a few frames reach the top pair and show that the session ends there. The short program pulse lets the bench send a follow-up frame while the previous pair is still busy, so the rejection of that frame is exercised. A protection floor in the middle of the small array places protected and unprotected pairs in a single session.

// File: rtl/aai_pkg.sv
// Shared types and opcode values for the auto-increment programming sequencer.
// Assumes opcodes arrive already decoded from the serial shift logic.
package aai_pkg;
    typedef enum logic [1:0] {
        FM_NONE  = 2'd0,
        FM_FIRST = 2'd1,
        FM_NEXT  = 2'd2
    } fmode_t;

    localparam logic [7:0] OP_AAI    = 8'hAD;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_RB_ON  = 8'h70;
    localparam logic [7:0] OP_RB_OFF = 8'h80;
endpackage

// File: rtl/aai_cmd_dec.sv
// Opcode decoder: keeps the write-enable latch and the ready/busy output
// setting, and chooses how the bytes of the current frame are interpreted.
// Assumes cmd_valid marks the first byte of a frame and that frame_end
// separates frames.
module aai_cmd_dec
    import aai_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_op,
    input  logic       frame_end,
    input  logic       sess,
    input  logic       busy,
    input  logic       top_hit,
    output fmode_t     fmode,
    output logic       wel,
    output logic       rb_en,
    output logic       wrdi
);
    assign wrdi = cmd_valid && (cmd_op == OP_WRDI);

    // Latch updates and the mode of the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmode <= FM_NONE;
            wel   <= 1'b0;
            rb_en <= 1'b0;
        end else begin
            if (top_hit)
                wel <= 1'b0;
            if (frame_end)
                fmode <= FM_NONE;
            if (cmd_valid) begin
                fmode <= FM_NONE;
                case (cmd_op)
                    OP_WREN:   if (!sess) wel <= 1'b1;
                    OP_WRDI:   wel <= 1'b0;
                    OP_RB_ON:  if (!sess) rb_en <= 1'b1;
                    OP_RB_OFF: if (!sess) rb_en <= 1'b0;
                    OP_AAI: begin
                        if (!busy) begin
                            if (sess)
                                fmode <= FM_NEXT;
                            else if (wel)
                                fmode <= FM_FIRST;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_AAI && !sess && !wel) |=> (fmode == FM_NONE)); // R1
    AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_AAI && busy) |=> (fmode == FM_NONE)); // R6
    AST_WEL_HELD_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && sess && cmd_op != OP_WRDI && !top_hit) |=> (wel == $past(wel))); // R7
    AST_RB_HELD_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && sess) |=> $stable(rb_en)); // R7
endmodule

// File: rtl/aai_frame_asm.sv
// Frame assembler: counts the bytes after the opcode, collects the start
// address and the two data bytes, and raises a one-cycle commit once a
// frame is complete. Assumes fmode is valid from the cycle after the opcode.
module aai_frame_asm
    import aai_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fmode_t        fmode,
    input  logic          cmd_valid,
    input  logic          frame_end,
    input  logic          dat_valid,
    input  logic [7:0]    dat_byte,
    output logic          commit,
    output logic          is_first,
    output logic [AW-1:0] start_addr,
    output logic [7:0]    d0,
    output logic [7:0]    d1
);
    localparam int IW = 3;
    localparam logic [IW-1:0] IDX_MAX = '1;

    logic [IW-1:0] idx;

    // Byte position, field capture and the commit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx        <= '0;
            commit     <= 1'b0;
            is_first   <= 1'b0;
            start_addr <= '0;
            d0         <= '0;
            d1         <= '0;
        end else begin
            commit <= 1'b0;
            if (cmd_valid || frame_end) begin
                idx <= '0;
            end else if (dat_valid && fmode != FM_NONE) begin
                if (idx != IDX_MAX)
                    idx <= idx + 1'b1;
                if (fmode == FM_FIRST) begin
                    case (idx)
                        3'd0, 3'd1, 3'd2: start_addr <= AW'({start_addr, dat_byte});
                        3'd3: d0 <= dat_byte;
                        3'd4: begin
                            d1       <= dat_byte;
                            commit   <= 1'b1;
                            is_first <= 1'b1;
                        end
                        default: ;
                    endcase
                end else begin
                    case (idx)
                        3'd0: d0 <= dat_byte;
                        3'd1: begin
                            d1       <= dat_byte;
                            commit   <= 1'b1;
                            is_first <= 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit); // R12
    AST_COMMIT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(fmode != FM_NONE && dat_valid)); // R12
endmodule

// File: rtl/aai_prog_engine.sv
// Program engine: keeps the session flag and the pair address, checks
// protection and the top of the array, writes the two bytes of a pair on
// consecutive cycles and times the program pulse.
// Assumes PROG_CYCLES >= 2, so that busy covers both write cycles.
module aai_prog_engine #(
    parameter int AW          = 22,
    parameter int PROG_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic          is_first,
    input  logic [AW-1:0] start_addr,
    input  logic [7:0]    d0,
    input  logic [7:0]    d1,
    input  logic          wrdi,
    input  logic          prot_on,
    input  logic [AW-1:0] prot_floor,
    output logic          sess,
    output logic          busy,
    output logic          top_hit,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [AW-1:0] ODD_BIT = AW'(1);

    logic [AW-1:0] base, cur_addr, wbase;
    logic [1:0]    stage;
    logic [7:0]    wd0, wd1;
    logic [CW-1:0] bcnt;
    logic          prot_hit;

    // Pair address, protection and top-of-array decode.
    always_comb begin
        base     = is_first ? (start_addr & ~ODD_BIT) : cur_addr;
        prot_hit = prot_on && ((base | ODD_BIT) >= prot_floor);
        top_hit  = commit && ((base | ODD_BIT) == '1);
    end

    assign busy      = (bcnt != '0);
    assign mem_we    = (stage != 2'd0);
    assign mem_addr  = wbase | AW'(stage == 2'd2);
    assign mem_wdata = (stage == 2'd2) ? wd1 : wd0;

    // Session state, write staging and program pulse timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sess     <= 1'b0;
            cur_addr <= '0;
            wbase    <= '0;
            stage    <= 2'd0;
            wd0      <= '0;
            wd1      <= '0;
            bcnt     <= '0;
        end else begin
            if (bcnt != '0)
                bcnt <= bcnt - 1'b1;
            stage <= (stage == 2'd1) ? 2'd2 : 2'd0;
            if (commit) begin
                sess     <= !top_hit;
                cur_addr <= base + AW'(2);
                if (!prot_hit) begin
                    stage <= 2'd1;
                    bcnt  <= CW'(PROG_CYCLES);
                    wbase <= base;
                    wd0   <= d0;
                    wd1   <= d1;
                end
            end
            if (wrdi)
                sess <= 1'b0;
        end
    end

    AST_WE_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R5
    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_addr[0]) |=> (mem_we && mem_addr[0])); // R4
    AST_WRDI_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        wrdi |=> !sess); // R8
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        top_hit |=> !sess); // R10
    AST_PROT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && prot_hit) |=> (!mem_we && !busy)); // R9
endmodule

// File: rtl/aai_word_prog.sv
// Top of the auto-increment word programming sequencer. Connects the opcode
// decoder, the frame assembler and the program engine, and forms the
// optional ready/busy output. Assumes strobed, already shifted opcodes and bytes.
module aai_word_prog
    import aai_pkg::*;
#(
    parameter int AW          = 22,
    parameter int PROG_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_op,
    input  logic          dat_valid,
    input  logic [7:0]    dat_byte,
    input  logic          frame_end,
    input  logic          prot_on,
    input  logic [AW-1:0] prot_floor,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          busy,
    output logic          aai_active,
    output logic          wel,
    output logic          so_oe,
    output logic          so_q
);
    fmode_t        fmode;
    logic          rb_en, wrdi, sess, top_hit, commit, is_first;
    logic [AW-1:0] start_addr;
    logic [7:0]    d0, d1;

    aai_cmd_dec u_dec (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .frame_end(frame_end), .sess(sess), .busy(busy), .top_hit(top_hit),
        .fmode(fmode), .wel(wel), .rb_en(rb_en), .wrdi(wrdi)
    );

    aai_frame_asm #(.AW(AW)) u_asm (
        .clk(clk), .rst_n(rst_n), .fmode(fmode), .cmd_valid(cmd_valid),
        .frame_end(frame_end), .dat_valid(dat_valid), .dat_byte(dat_byte),
        .commit(commit), .is_first(is_first), .start_addr(start_addr),
        .d0(d0), .d1(d1)
    );

    aai_prog_engine #(.AW(AW), .PROG_CYCLES(PROG_CYCLES)) u_eng (
        .clk(clk), .rst_n(rst_n), .commit(commit), .is_first(is_first),
        .start_addr(start_addr), .d0(d0), .d1(d1), .wrdi(wrdi),
        .prot_on(prot_on), .prot_floor(prot_floor), .sess(sess), .busy(busy),
        .top_hit(top_hit), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    assign aai_active = sess;
    assign so_oe      = rb_en && sess;
    assign so_q       = !busy;

    AST_SO_ONLY_IN_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> aai_active); // R11
endmodule

// File: tb/aai_word_prog_tb_top.sv
module aai_word_prog_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int PC = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, dat_valid = 1'b0, frame_end = 1'b0, prot_on = 1'b0;
    logic [7:0] cmd_op = 8'h00, dat_byte = 8'h00;
    logic [AW-1:0] prot_floor = '0;
    logic mem_we, busy, aai_active, wel, so_oe, so_q;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    aai_word_prog #(.AW(AW), .PROG_CYCLES(PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .dat_valid(dat_valid), .dat_byte(dat_byte), .frame_end(frame_end),
        .prot_on(prot_on), .prot_floor(prot_floor), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
        .aai_active(aai_active), .wel(wel), .so_oe(so_oe), .so_q(so_q)
    );

    // Array model: a write can only clear bits.
    logic [7:0] arr [DEPTH];
    initial for (int i = 0; i < DEPTH; i++) arr[i] = 8'hFF;
    always @(posedge clk) if (mem_we) arr[mem_addr] <= arr[mem_addr] & mem_wdata;

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int m_wel, m_sess, m_rb, m_mode, m_idx, m_a, m_d0, m_d1, m_commit, m_first;
    int m_cur, m_busy;
    int wq[$];
    always @(posedge clk) begin
        int o_sess, o_busy, o_mode, o_wel, c, top, base;
        if (!rst_n) begin
            m_wel = 0; m_sess = 0; m_rb = 0; m_mode = 0; m_idx = 0; m_a = 0;
            m_d0 = 0; m_d1 = 0; m_commit = 0; m_first = 0; m_cur = 0; m_busy = 0;
            wq.delete();
        end else begin
            o_sess = m_sess; o_busy = (m_busy > 0); o_mode = m_mode; o_wel = m_wel;
            c = m_commit; m_commit = 0; top = 0;
            if (wq.size() > 0) void'(wq.pop_front());
            if (m_busy > 0) m_busy--;
            if (c != 0) begin
                base = m_first ? ((m_a % DEPTH) & ~1) : m_cur;
                top = (base == DEPTH - 2);
                m_sess = !top;
                m_cur = (base + 2) % DEPTH;
                if (!(prot_on && (base + 1) >= int'(prot_floor))) begin
                    wq.push_back(base * 256 + m_d0);
                    wq.push_back((base + 1) * 256 + m_d1);
                    m_busy = PC;
                end
            end
            if (cmd_valid && cmd_op == 8'h04) m_sess = 0;
            if (top != 0) m_wel = 0;
            if (frame_end) m_mode = 0;
            if (cmd_valid) begin
                m_mode = 0;
                case (cmd_op)
                    8'h06: if (o_sess == 0) m_wel = 1;
                    8'h04: m_wel = 0;
                    8'h70: if (o_sess == 0) m_rb = 1;
                    8'h80: if (o_sess == 0) m_rb = 0;
                    8'hAD: if (o_busy == 0) begin
                        if (o_sess != 0) m_mode = 2;
                        else if (o_wel != 0) m_mode = 1;
                    end
                    default: ;
                endcase
            end
            if (cmd_valid || frame_end) m_idx = 0;
            else if (dat_valid && o_mode != 0) begin
                if (o_mode == 1) begin
                    if (m_idx <= 2) m_a = ((m_a << 8) | int'(dat_byte)) & 32'hFFFFFF;
                    else if (m_idx == 3) m_d0 = dat_byte;
                    else if (m_idx == 4) begin m_d1 = dat_byte; m_commit = 1; m_first = 1; end
                end else begin
                    if (m_idx == 0) m_d0 = dat_byte;
                    else if (m_idx == 1) begin m_d1 = dat_byte; m_commit = 1; m_first = 0; end
                end
                if (m_idx < 7) m_idx++;
            end
        end
    end

    // Per-cycle comparison with the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 busy", busy, m_busy > 0);
            chk("R2 aai_active", aai_active, m_sess);
            chk("R1 wel", wel, m_wel);
            chk("R11 so_oe", so_oe, (m_rb != 0) && (m_sess != 0));
            chk("R11 so_q", so_q, !(m_busy > 0));
            chk("R4 mem_we", mem_we, wq.size() > 0);
            if (mem_we && wq.size() > 0) begin
                chk("R3 mem_addr", mem_addr, wq[0] / 256);
                chk("R3 mem_wdata", mem_wdata, wq[0] % 256);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic put_cmd(input logic [7:0] op);
        cmd_valid = 1'b1; cmd_op = op; @(negedge clk); cmd_valid = 1'b0;
    endtask
    task automatic put_byte(input logic [7:0] b);
        dat_valid = 1'b1; dat_byte = b; @(negedge clk); dat_valid = 1'b0;
    endtask
    task automatic put_end();
        frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
    endtask
    task automatic op_frame(input logic [7:0] op);
        put_cmd(op); put_end(); idle(2);
    endtask
    task automatic aai_first(input int a, input logic [7:0] b0, input logic [7:0] b1);
        put_cmd(8'hAD); put_byte(8'(a >> 16)); put_byte(8'(a >> 8)); put_byte(8'(a));
        put_byte(b0); put_byte(b1); put_end();
    endtask
    task automatic aai_next(input logic [7:0] b0, input logic [7:0] b1);
        put_cmd(8'hAD); put_byte(b0); put_byte(b1); put_end();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 reset wel", wel, 0);
        chk("R2 reset active", aai_active, 0);
        chk("R5 reset busy", busy, 0);
        chk("R11 reset so_oe", so_oe, 0);

        // R1: no write-enable, frame ignored
        aai_first(4, 8'h12, 8'h34); idle(6);
        chk("R1 no start without wel", aai_active, 0);
        chk("R1 array untouched", arr[4], 8'hFF);

        // R11 on, R2 first frame with odd start address
        op_frame(8'h70);
        op_frame(8'h06);
        aai_first(5, 8'hA1, 8'hB2);
        chk("R2 session started", aai_active, 1);
        chk("R11 so_oe in session", so_oe, 1);
        // R6: frame sent while busy is dropped
        aai_next(8'hC0, 8'hC1);
        idle(6);
        chk("R2 even byte", arr[4], 8'hA1);
        chk("R2 odd byte", arr[5], 8'hB2);
        aai_next(8'hC3, 8'hD4); idle(6);
        chk("R6 busy frame dropped, R3 next pair", arr[6], 8'hC3);
        chk("R3 next pair odd", arr[7], 8'hD4);

        // R7: other opcodes mid-session
        op_frame(8'h80);
        op_frame(8'h03);
        op_frame(8'h06);
        chk("R7 so_oe kept", so_oe, 1);
        chk("R7 session kept", aai_active, 1);

        // R12: short frame, then frame with an extra byte
        put_cmd(8'hAD); put_byte(8'hE0); put_end(); idle(4);
        chk("R12 short frame no write", arr[8], 8'hFF);
        aai_next(8'hE5, 8'hF6); idle(6);
        chk("R12 pair after short frame", arr[8], 8'hE5);
        put_cmd(8'hAD); put_byte(8'h17); put_byte(8'h27); put_byte(8'h37); put_end(); idle(6);
        chk("R12 extra byte even", arr[10], 8'h17);
        chk("R12 extra byte odd", arr[11], 8'h27);
        chk("R12 extra byte not written", arr[12], 8'hFF);

        // R8: write-disable ends the session
        op_frame(8'h04);
        chk("R8 session ended", aai_active, 0);
        chk("R8 wel cleared", wel, 0);
        aai_next(8'h99, 8'h99); idle(6);
        chk("R8 later frame ignored", arr[12], 8'hFF);

        // R9: protection floor at 0x20
        prot_on = 1'b1; prot_floor = 6'h20;
        op_frame(8'h06);
        aai_first(6'h1E, 8'h11, 8'h22); idle(6);
        aai_next(8'h33, 8'h44); idle(6);
        aai_next(8'h55, 8'h66); idle(6);
        prot_on = 1'b0;
        aai_next(8'h77, 8'h88); idle(6);
        chk("R9 below floor written", arr[6'h1E], 8'h11);
        chk("R9 protected pair", arr[6'h20], 8'hFF);
        chk("R9 protected pair 2", arr[6'h22], 8'hFF);
        chk("R9 address advanced", arr[6'h24], 8'h77);
        chk("R9 address advanced odd", arr[6'h25], 8'h88);

        // R10: top of array
        op_frame(8'h04);
        op_frame(8'h06);
        aai_first(6'h3C, 8'h01, 8'h02); idle(6);
        aai_next(8'h03, 8'h04); idle(6);
        chk("R10 top pair written", arr[6'h3F], 8'h04);
        chk("R10 session ended", aai_active, 0);
        chk("R10 wel cleared", wel, 0);
        aai_next(8'h05, 8'h06); idle(6);
        chk("R10 no wrap", arr[0], 8'hFF);

        // R11: ready/busy output turned off
        op_frame(8'h80);
        op_frame(8'h06);
        aai_first(6'h30, 8'h0A, 8'h0B);
        chk("R11 so_oe off", so_oe, 0);
        chk("R11 session on", aai_active, 1);
        idle(6);
        op_frame(8'h04);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule